// File: doc/BRIEF.md
# Self-Routing Delay-Line Multiplexer Path Controller

This block steers cells through a multiplexer built from a chain of crossbar switches and fixed delay lines. The multiplexer has N inputs, where N is a power of two, and STAGES switching stages. It holds at most N^STAGES - 1 cells. The block keeps one piece of state: the count of stored cells. It recomputes every slot the route of each cell that arrives in that slot, so the switches need no arbitration.

Each clock cycle is one slot, and one cell leaves the multiplexer per slot whenever the multiplexer is not empty.

The cells arriving in a slot are ranked in descending input order. A cell of rank r gets a virtual delay equal to the stored count plus r. That delay, written in base N, is the cell's route: digit j selects the output taken at stage j. A cell whose delay would exceed the capacity is dropped. The first stage then sends it to one of its N-1 extra loss outputs.

All route outputs are combinational from the current stored count and the arrival vector. The stored count advances at the clock edge.

Top module: `selfroute_ctl`

## Requirements
- R1: Following reset the stored count reads 0. With no arrivals, every route, port and drop output is 0.
- R2: At each clock edge the stored count becomes min(max(0, q + a - 1), N^STAGES - 1). Here q is the count before the edge and a is the number of set bits of `arrV`.
- R3: Cells arriving in one slot are ranked from the highest input index down, starting at rank 0. A kept cell of rank r has its whole `stageSel` field for its input, bits [i*QW +: QW], equal to q + r.
- R4: In the field of input i, the stage-j digit sits at bits [i*QW + j*LOGN +: LOGN]. It equals digit j of the virtual delay in base N, with stage 0 the least significant digit.
- R5: An arriving cell is dropped (its `dropV` bit is 1) exactly when q + r > N^STAGES - 1. A dropped cell's `stageSel` field is 0.
- R6: The first-stage port of input i is `firstPort` bits [i*(LOGN+1) +: LOGN+1]. For a kept cell it equals stage-0 digit (a value below N). For a dropped cell it equals N + (q + r - N^STAGES), an index among the N-1 loss outputs.
- R7: An input with no arrival shows 0 on its `dropV` bit, its `stageSel` field and its `firstPort` field, whatever the stored count.
- R8: When the multiplexer is full and all N inputs deliver a cell, exactly N-1 cells are dropped and the stored count stays at N^STAGES - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, one slot per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| arrV | input | N | Cell present on each input this slot |
| stageSel | output | N*QW | Per input, the base-N route digits of the cell's virtual delay |
| firstPort | output | N*(LOGN+1) | Per input, first-stage output index, including the loss outputs |
| dropV | output | N | Per input, cell dropped for overflow |
| occupancy | output | QW | Stored cell count |

## Verification
A wrong stored count shows up in the same slot it arises. Every arriving cell's route digits are offset from the count, so the first arrival after the fault carries a wrong delay. The `occupancy` port shows the error one edge later.

A wrong rank order makes two kept cells of one slot swap delays, which appears only in slots with two or more arrivals. A wrong clamp or overflow threshold shows only near the full level: either cells are kept past capacity, or the loss-output indices drift.

The sweep therefore drives every arrival pattern at every stored level, and adds long streams both at full load and draining.

// File: rtl/selfroute_pkg.sv
package selfroute_pkg;

  // Command from the rank/control logic to the occupancy datapath.
  typedef struct packed {
    logic stay0;      // nothing stored and nothing arriving: hold at zero
    logic clampFull;  // next count would pass capacity: saturate
  } occCmd_t;

endpackage

// File: rtl/selfroute_rank.sv
module selfroute_rank
  import selfroute_pkg::*;
#(
  parameter int LOGN   = 2,
  parameter int STAGES = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [(1<<LOGN)-1:0]       arrV,
  input  logic [LOGN*STAGES-1:0]     occQ,
  output logic [(1<<LOGN)-1:0][LOGN:0] rankA,
  output logic [LOGN:0]              arrCnt,
  output occCmd_t                    cmd
);
  localparam int NIN = 1 << LOGN;
  localparam int QW  = LOGN * STAGES;
  localparam int CW  = LOGN + 1;
  localparam int SW  = QW + 1;
  localparam logic [SW-1:0] CAP_P1 = {1'b1, {QW{1'b0}}};

  logic [CW-1:0] acc;
  logic [SW-1:0] total;

  // Rank = number of arrivals on higher-numbered inputs.
  always_comb begin
    acc = '0;
    for (int i = NIN - 1; i >= 0; i--) begin
      rankA[i] = acc;
      acc      = acc + CW'(arrV[i]);
    end
    arrCnt = acc;
  end

  always_comb begin
    total         = SW'(occQ) + SW'(arrCnt);
    cmd.stay0     = (total == '0);
    cmd.clampFull = (total > CAP_P1);
  end

  // R3: the highest arrived input always has rank 0
  AST_TOP_RANK0: assert property (@(posedge clk) disable iff (!rstN)
    arrV[NIN-1] |-> rankA[NIN-1] == '0); // R3

  // R2: stay-at-zero and saturation never requested together
  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.stay0 && cmd.clampFull)); // R2

  generate
    for (genvar g = 1; g < NIN; g++) begin : g_rank_chk
      // R3: a lower input that also arrives is ranked one above its neighbour
      AST_RANK_STEP: assert property (@(posedge clk) disable iff (!rstN)
        (arrV[g] && arrV[g-1]) |-> rankA[g-1] == rankA[g] + CW'(1)); // R3
    end
  endgenerate

endmodule

// File: rtl/selfroute_occ.sv
module selfroute_occ
  import selfroute_pkg::*;
#(
  parameter int LOGN   = 2,
  parameter int STAGES = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [(1<<LOGN)-1:0]         arrV,
  input  logic [(1<<LOGN)-1:0][LOGN:0] rankA,
  input  logic [LOGN:0]                arrCnt,
  input  occCmd_t                      cmd,
  output logic [LOGN*STAGES-1:0]       occQ,
  output logic [(1<<LOGN)*LOGN*STAGES-1:0] stageSel,
  output logic [(1<<LOGN)*(LOGN+1)-1:0]    firstPort,
  output logic [(1<<LOGN)-1:0]         dropV
);
  localparam int NIN = 1 << LOGN;
  localparam int QW  = LOGN * STAGES;
  localparam int FW  = LOGN + 1;
  localparam int SW  = QW + 1;
  localparam logic [QW-1:0] FULL = {QW{1'b1}};

  logic [SW-1:0] grow;

  always_comb grow = SW'(occQ) + SW'(arrCnt) - SW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              occQ <= '0;
    else if (cmd.stay0)     occQ <= '0;
    else if (cmd.clampFull) occQ <= FULL;
    else                    occQ <= grow[QW-1:0];
  end

  generate
    for (genvar g = 0; g < NIN; g++) begin : g_cell
      logic [SW-1:0] vDelay;
      logic          over;

      always_comb begin
        vDelay = SW'(occQ) + SW'(rankA[g]);
        over   = vDelay[QW];
        dropV[g] = arrV[g] & over;
        stageSel[g*QW +: QW] = (arrV[g] && !over) ? vDelay[QW-1:0] : '0;
        if (!arrV[g])  firstPort[g*FW +: FW] = '0;
        else           firstPort[g*FW +: FW] = {over, vDelay[LOGN-1:0]};
      end

      // R7: an idle input drives nothing
      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
        !arrV[g] |-> (!dropV[g] && stageSel[g*QW +: QW] == '0
                      && firstPort[g*FW +: FW] == '0)); // R7

      // R6: a dropped cell leaves on a loss output, index at least N
      AST_DROP_LOSSPORT: assert property (@(posedge clk) disable iff (!rstN)
        dropV[g] |-> firstPort[g*FW + LOGN]); // R6
    end

    for (genvar g = 1; g < NIN; g++) begin : g_drop_order
      // R5: drops fall on the later-ranked (lower-index) cells
      AST_DROP_SUFFIX: assert property (@(posedge clk) disable iff (!rstN)
        (dropV[g] && arrV[g-1]) |-> dropV[g-1]); // R5
    end
  endgenerate

  // R3: the highest-index arrival is routed with delay equal to the count
  AST_HEAD_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    arrV[NIN-1] |-> stageSel[(NIN-1)*QW +: QW] == occQ); // R3

  // R2: with no arrivals the count drains by one per slot
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (arrV == '0 && occQ != '0) |=> occQ == $past(occQ) - QW'(1)); // R2

  // R2: empty and idle stays empty
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (arrV == '0 && occQ == '0) |=> occQ == '0); // R2

  // R8: any drop leaves the multiplexer full
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (|dropV) |=> occQ == FULL); // R8

endmodule

// File: rtl/selfroute_ctl.sv
module selfroute_ctl
  import selfroute_pkg::*;
#(
  parameter int LOGN   = 2,
  parameter int STAGES = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [(1<<LOGN)-1:0]                 arrV,
  output logic [(1<<LOGN)*LOGN*STAGES-1:0]     stageSel,
  output logic [(1<<LOGN)*(LOGN+1)-1:0]        firstPort,
  output logic [(1<<LOGN)-1:0]                 dropV,
  output logic [LOGN*STAGES-1:0]               occupancy
);
  localparam int NIN = 1 << LOGN;
  localparam int QW  = LOGN * STAGES;

  logic [NIN-1:0][LOGN:0] rankA;
  logic [LOGN:0]          arrCnt;
  occCmd_t                cmd;
  logic [QW-1:0]          occQ;

  selfroute_rank #(.LOGN(LOGN), .STAGES(STAGES)) u_rank (
    .clk    (clk),
    .rstN   (rstN),
    .arrV   (arrV),
    .occQ   (occQ),
    .rankA  (rankA),
    .arrCnt (arrCnt),
    .cmd    (cmd)
  );

  selfroute_occ #(.LOGN(LOGN), .STAGES(STAGES)) u_occ (
    .clk       (clk),
    .rstN      (rstN),
    .arrV      (arrV),
    .rankA     (rankA),
    .arrCnt    (arrCnt),
    .cmd       (cmd),
    .occQ      (occQ),
    .stageSel  (stageSel),
    .firstPort (firstPort),
    .dropV     (dropV)
  );

  assign occupancy = occQ;

endmodule

// File: tb/selfroute_ctl_tb.sv
module selfroute_ctl_tb;
  localparam int LOGN   = 2;
  localparam int STAGES = 2;
  localparam int NIN    = 1 << LOGN;
  localparam int QW     = LOGN * STAGES;
  localparam int FW     = LOGN + 1;
  localparam int CAP    = (1 << QW) - 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [NIN-1:0]      arrV = '0;
  logic [NIN*QW-1:0]   stageSel;
  logic [NIN*FW-1:0]   firstPort;
  logic [NIN-1:0]      dropV;
  logic [QW-1:0]       occupancy;

  int nChk = 0;
  int nBad = 0;
  int mq = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  selfroute_ctl #(.LOGN(LOGN), .STAGES(STAGES)) u_dut (
    .clk(clk), .rstN(rstN), .arrV(arrV), .stageSel(stageSel),
    .firstPort(firstPort), .dropV(dropV), .occupancy(occupancy)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s got=%0d expected=%0d (q=%0d arr=%b)", tag, got, exp, mq, arrV);
    end
  endtask

  task automatic runSlot(input logic [NIN-1:0] pat);
    int r, d, drops, cnt, s, nq, eSel, eFirst, gSel, gFirst, gDig, eDig;
    bit eDrop;
    @(negedge clk);
    arrV = pat;
    #2;
    r = 0; drops = 0; cnt = 0;
    for (int i = NIN - 1; i >= 0; i--) begin
      gSel   = int'(stageSel[i*QW +: QW]);
      gFirst = int'(firstPort[i*FW +: FW]);
      if (pat[i]) begin
        d = mq + r; r++; cnt++;
        if (d > CAP) begin
          eDrop = 1; eSel = 0; eFirst = NIN + (d - CAP - 1); drops++;
          chk(dropV[i] == 1'b1, "R5 drop flag", int'(dropV[i]), 1);
          chk(gSel == 0, "R5 dropped route zero", gSel, 0);
        end else begin
          eDrop = 0; eSel = d; eFirst = d % NIN;
          chk(dropV[i] == 1'b0, "R5 kept flag", int'(dropV[i]), 0);
          chk(gSel == eSel, "R3 virtual delay", gSel, eSel);
          for (int j = 0; j < STAGES; j++) begin
            gDig = int'(stageSel[i*QW + j*LOGN +: LOGN]);
            eDig = (eSel >> (j*LOGN)) % NIN;
            chk(gDig == eDig, "R4 stage digit", gDig, eDig);
          end
        end
        chk(gFirst == eFirst, "R6 first-stage port", gFirst, eFirst);
      end else begin
        chk(dropV[i] == 1'b0 && gSel == 0 && gFirst == 0, "R7 idle input quiet",
            gSel + gFirst + int'(dropV[i]), 0);
      end
    end
    if (pat == '1 && mq == CAP)
      chk(drops == NIN - 1, "R8 full-load drops", drops, NIN - 1);
    s  = mq + cnt;
    nq = (s == 0) ? 0 : ((s - 1 > CAP) ? CAP : s - 1);
    @(posedge clk);
    #1;
    mq = nq;
    chk(int'(occupancy) == mq, "R2 stored count", int'(occupancy), mq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    int          tgt, a;
    logic [NIN-1:0] p;
    repeat (3) @(posedge clk);
    #1;
    chk(occupancy == '0, "R1 reset count", int'(occupancy), 0);
    chk(stageSel == '0 && firstPort == '0 && dropV == '0, "R1 reset outputs",
        int'(stageSel) + int'(firstPort) + int'(dropV), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk(occupancy == '0, "R1 count after release", int'(occupancy), 0);

    // Every arrival pattern at every stored level
    for (int lvl = 0; lvl <= CAP; lvl++) begin
      for (int pat = 0; pat < (1 << NIN); pat++) begin
        while (mq != lvl) begin
          if (mq > lvl) runSlot('0);
          else begin
            tgt = lvl - mq + 1;
            a = (tgt > NIN) ? NIN : tgt;
            runSlot(NIN'((1 << a) - 1));
          end
        end
        runSlot(NIN'(pat));
      end
    end

    // Sustained full load
    repeat (20) runSlot('1);
    // Drain to empty and linger
    repeat (CAP + 4) runSlot('0);

    // Mixed pseudo-random traffic
    lcg = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      p = lcg[20 +: NIN];
      if (lcg[30]) p = p & lcg[8 +: NIN];
      runSlot(p);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule